// File: doc/BRIEF.md
# Left-to-Right Justification Converter for Serial Audio

This block sits between a digital audio receiver and an 18-bit serial DAC. Both parts share one bit clock. The receiver sends stereo samples as 24-bit words that begin at each change of the word-select line. The DAC expects 18-bit words that end right at each change of its word-select line. The converter passes the 18 most significant bits of each incoming word and drives every later bit period to zero. It also moves the word-select edge to the point where 18 bits of the current word have gone by, so the kept bits sit right-justified against the new edge.

A second mode accepts a 16-bit right-justified stream instead. In that mode word-select passes through unchanged. Only the final 16 bit periods before each edge carry data, so the word reaches the DAC as an 18-bit value whose two leading bits are zero.

A small bit counter tracks the position inside each half-frame. The gating decision is registered on the rising edge of the bit clock, and the outputs change on the falling edge, so the DAC can sample on its rising edge.

Top module: `audio_justify_conv`

## Requirements
- R1: In mode 0 (24-bit left-justified input), once armed, the bits at positions 0 to 17 of each half-frame appear on `sd_out` unchanged. Position 0 is the bit sampled at the rising edge where the new `ws_in` level is first seen.
- R2: In mode 0, every bit period at position 18 or later in a half-frame drives `sd_out` to 0, whatever `sd_in` carries.
- R3: In mode 0, `ws_out` equals the `ws_in` level of the current half-frame for positions 0 to 17 and its inverse from position 18 onward. The word output during a level therefore belongs to that channel (high = left, low = right).
- R4: The bit position restarts at 0 on every `ws_in` transition, in either direction.
- R5: The position counter saturates at 31, so half-frames longer than 32 bit clocks still convert correctly in mode 0.
- R6: Inputs are sampled on the rising edge of `bclk`. The result for that bit appears on `sd_out` and `ws_out` at the following falling edge and holds for one full bit period.
- R7: In mode 1 (16-bit right-justified input), `ws_out` follows `ws_in`. Once armed, only the last 16 bit periods of each half-frame pass to `sd_out`; all earlier bit periods, including the two just before the data, read 0. The half-frame length is taken from the half-frame just ended.
- R8: `sd_out` stays 0 from reset until the second `ws_in` transition, that is, until one complete half-frame has been seen.
- R9: `bclk_out` is `bclk` passed straight through.
- R10: `mode_in` is sampled only at a `ws_in` transition. A change between transitions has no effect on the half-frame in progress.
- R11: While `rst_n` is low, `sd_out` and `ws_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock shared by source and DAC |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws_in | input | 1 | Incoming word select, high = left channel |
| sd_in | input | 1 | Incoming serial data, MSB first |
| mode_in | input | 1 | 0 = 24-bit left-justified input, 1 = 16-bit right-justified input |
| bclk_out | output | 1 | Bit clock forwarded to the DAC |
| ws_out | output | 1 | Regenerated word select, high = left channel |
| sd_out | output | 1 | 18-bit right-justified serial data |

## Verification
The hardest states to reach are those that depend on frame history rather than on the current bit: the arming point two word-select edges after reset, the counter sitting at saturation, and a mode change arriving mid-half-frame. The bench drives whole frames from reset for a sweep of half-frame lengths in both modes. The sweep covers exactly 18 and 24 bits, a length that is not a power of two, 32 bits, and 40 bits, which pushes the counter into saturation. Filler ones fill every discarded bit period so that any leak shows on the output. One run in mode 0 pulses `mode_in` high inside a half-frame and expects the output stream to be unchanged.

// File: rtl/sj_pkg.sv
package sj_pkg;

  typedef enum logic {
    MODE_LJ24 = 1'b0,
    MODE_RJ16 = 1'b1
  } sj_mode_e;

  // left-justified input: a bit is kept while its position is inside the kept field
  function automatic logic lj_keep(input int pos, input int keep);
    return pos < keep;
  endfunction

  // left-justified input: word select flips once the kept field has passed
  function automatic logic lj_ws(input logic ws, input int pos, input int keep);
    return (pos >= keep) ? ~ws : ws;
  endfunction

  // right-justified input: a bit is kept when it lies in the last `width` slots
  function automatic logic rj_keep(input int pos, input int len, input int width);
    return (pos + width) >= len;
  endfunction

endpackage

// File: rtl/sj_edge_track.sv
module sj_edge_track
  import sj_pkg::*;
(
  input  logic     bclk,
  input  logic     rst_n,
  input  logic     ws_in,
  input  logic     mode_in,
  output logic     ws_edge,
  output logic     arm_eff,
  output sj_mode_e mode_eff
);

  logic     started_q;
  logic     ws_q;
  logic     seen_q;
  logic     armed_q;
  sj_mode_e mode_q;

  assign ws_edge  = started_q & (ws_in ^ ws_q);
  assign arm_eff  = armed_q | (ws_edge & seen_q);
  assign mode_eff = ws_edge ? sj_mode_e'(mode_in) : mode_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      ws_q      <= 1'b0;
      seen_q    <= 1'b0;
      armed_q   <= 1'b0;
      mode_q    <= MODE_LJ24;
    end else begin
      started_q <= 1'b1;
      ws_q      <= ws_in;
      seen_q    <= seen_q | ws_edge;
      armed_q   <= arm_eff;
      mode_q    <= mode_eff;
    end
  end

endmodule

// File: rtl/sj_bit_counter.sv
module sj_bit_counter #(
  parameter int CW = 5
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          ws_edge,
  output logic [CW-1:0] bit_idx,
  output logic [CW:0]   len_eff
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW:0]   LEN_ONE = {{CW{1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW:0]   len_q;

  always_comb begin
    if (ws_edge)               bit_idx = '0;
    else if (cnt_q == CNT_MAX) bit_idx = CNT_MAX;
    else                       bit_idx = cnt_q + CNT_ONE;
  end

  // length of the half-frame that ends at this edge
  assign len_eff = ws_edge ? ({1'b0, cnt_q} + LEN_ONE) : len_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= bit_idx;
      len_q <= len_eff;
    end
  end

endmodule

// File: rtl/sj_gate.sv
module sj_gate
  import sj_pkg::*;
#(
  parameter int KEEP = 18,
  parameter int RJ_W = 16,
  parameter int CW   = 5
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          sd_in,
  input  logic          ws_in,
  input  logic [CW-1:0] bit_idx,
  input  logic [CW:0]   len_eff,
  input  sj_mode_e      mode_eff,
  input  logic          arm_eff,
  output logic          d_r,
  output logic          w_r
);

  logic keep_w;
  logic ws_w;

  always_comb begin
    if (mode_eff == MODE_LJ24) begin
      keep_w = lj_keep(int'(bit_idx), KEEP);
      ws_w   = lj_ws(ws_in, int'(bit_idx), KEEP);
    end else begin
      keep_w = rj_keep(int'(bit_idx), int'(len_eff), RJ_W);
      ws_w   = ws_in;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      d_r <= 1'b0;
      w_r <= 1'b0;
    end else begin
      d_r <= arm_eff & keep_w & sd_in;
      w_r <= ws_w;
    end
  end

endmodule

// File: rtl/sj_out_stage.sv
module sj_out_stage (
  input  logic bclk,
  input  logic rst_n,
  input  logic d_r,
  input  logic w_r,
  output logic sd_out,
  output logic ws_out
);

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sd_out <= 1'b0;
      ws_out <= 1'b0;
    end else begin
      sd_out <= d_r;
      ws_out <= w_r;
    end
  end

endmodule

// File: rtl/audio_justify_conv.sv
module audio_justify_conv
  import sj_pkg::*;
#(
  parameter int KEEP = 18,
  parameter int RJ_W = 16,
  parameter int CW   = 5
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic ws_in,
  input  logic sd_in,
  input  logic mode_in,
  output logic bclk_out,
  output logic ws_out,
  output logic sd_out
);

  logic          ws_edge;
  logic          arm_eff;
  sj_mode_e      mode_eff;
  logic [CW-1:0] bit_idx;
  logic [CW:0]   len_eff;
  logic          d_r;
  logic          w_r;

  assign bclk_out = bclk;

  sj_edge_track u_edge (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .ws_in   (ws_in),
    .mode_in (mode_in),
    .ws_edge (ws_edge),
    .arm_eff (arm_eff),
    .mode_eff(mode_eff)
  );

  sj_bit_counter #(.CW(CW)) u_cnt (
    .bclk   (bclk),
    .rst_n  (rst_n),
    .ws_edge(ws_edge),
    .bit_idx(bit_idx),
    .len_eff(len_eff)
  );

  sj_gate #(.KEEP(KEEP), .RJ_W(RJ_W), .CW(CW)) u_gate (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .sd_in   (sd_in),
    .ws_in   (ws_in),
    .bit_idx (bit_idx),
    .len_eff (len_eff),
    .mode_eff(mode_eff),
    .arm_eff (arm_eff),
    .d_r     (d_r),
    .w_r     (w_r)
  );

  sj_out_stage u_out (
    .bclk  (bclk),
    .rst_n (rst_n),
    .d_r   (d_r),
    .w_r   (w_r),
    .sd_out(sd_out),
    .ws_out(ws_out)
  );

endmodule

// File: rtl/sj_checker.sv
module sj_checker
  import sj_pkg::*;
#(
  parameter int KEEP = 18,
  parameter int CW   = 5
) (
  input logic          bclk,
  input logic          rst_n,
  input logic          ws_in,
  input logic          ws_edge,
  input logic          arm_eff,
  input sj_mode_e      mode_eff,
  input logic [CW-1:0] bit_idx,
  input logic          ws_out,
  input logic          sd_out
);

  // R8: nothing leaves before arming
  p_hold_zero_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    !arm_eff |-> !sd_out);

  // R10: mode stays put between word-select edges
  p_mode_hold_r10: assert property (@(posedge bclk) disable iff (!rst_n)
    !ws_edge |-> $stable(mode_eff));

  // R2: the tail of a 24-bit word is blanked
  p_lj_tail_r2: assert property (@(posedge bclk) disable iff (!rst_n)
    ($past(mode_eff) == MODE_LJ24 && int'($past(bit_idx)) >= KEEP) |-> !sd_out);

  // R3: word select inverted once the kept field has passed
  p_lj_ws_r3: assert property (@(posedge bclk) disable iff (!rst_n)
    ($past(mode_eff) == MODE_LJ24 && int'($past(bit_idx)) >= KEEP) |-> (ws_out != $past(ws_in)));

  // R7: word select passes through in 16-bit mode
  p_rj_ws_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    ($past(mode_eff) == MODE_RJ16) |-> (ws_out == $past(ws_in)));

endmodule

bind audio_justify_conv sj_checker #(.KEEP(KEEP), .CW(CW)) u_chk (
  .bclk    (bclk),
  .rst_n   (rst_n),
  .ws_in   (ws_in),
  .ws_edge (ws_edge),
  .arm_eff (arm_eff),
  .mode_eff(mode_eff),
  .bit_idx (bit_idx),
  .ws_out  (ws_out),
  .sd_out  (sd_out)
);

// File: tb/sim_audio_justify_conv.sv
module sim_audio_justify_conv;

  localparam int PERIOD = 10;
  localparam int KEEP   = 18;
  localparam int RJ_W   = 16;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic ws_in = 1'b0;
  logic sd_in = 1'b0;
  logic mode_in = 1'b0;
  logic bclk_out, ws_out, sd_out;

  int checks = 0;
  int errors = 0;

  // two-stage expectation pipeline: input driven at step t shows at step t+2
  logic  v1 = 1'b0, v2 = 1'b0;
  logic  e1sd, e1ws, e2sd, e2ws;
  string t1sd, t1ws, t2sd, t2ws;

  always #(PERIOD/2) bclk = ~bclk;

  audio_justify_conv u0 (
    .bclk(bclk), .rst_n(rst_n), .ws_in(ws_in), .sd_in(sd_in), .mode_in(mode_in),
    .bclk_out(bclk_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  task automatic check(input logic act, input logic exp, input string tg);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tg, act, exp, $time);
    end
  endtask

  task automatic step(input logic ws, input logic sd, input logic ev,
                      input logic esd, input logic ews, input string tsd, input string tws);
    @(posedge bclk);
    #1;
    if (v2) begin
      check(sd_out, e2sd, tsd.len() > 0 ? t2sd : t2sd);
      check(ws_out, e2ws, t2ws);
    end
    v2 = v1; e2sd = e1sd; e2ws = e1ws; t2sd = t1sd; t2ws = t1ws;
    #1;
    ws_in = ws; sd_in = sd;
    v1 = ev; e1sd = esd; e1ws = ews; t1sd = tsd; t1ws = tws;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; mode_in = mode; ws_in = 1'b0; sd_in = 1'b0;
    v1 = 1'b0; v2 = 1'b0;
    repeat (3) @(posedge bclk);
    #3;
    check(sd_out, 1'b0, "R11 sd_out in reset");
    check(ws_out, 1'b0, "R11 ws_out in reset");
    @(posedge bclk);
    #1 rst_n = 1'b1;
  endtask

  function automatic logic [23:0] word_of(input int h, input int len);
    return 24'(h * 24'h05A3C7 + len * 24'h0001F1 + 24'h000813);
  endfunction

  // mode 0 run (len may exceed 32) or mode 1 run; glitch pulses mode_in mid-frame
  task automatic run(input logic mode, input int len, input int halves, input logic glitch);
    string extra;
    extra = (len > 32) ? " R5" : (glitch ? " R10" : "");
    do_reset(mode);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 idle", "R4 idle ws");
    for (int h = 0; h < halves; h++) begin
      logic        wsl;
      logic [23:0] w;
      wsl = (h % 2 == 0);
      w   = word_of(h, len);
      for (int j = 0; j < len; j++) begin
        logic  b, esd, ews;
        string tsd, tws;
        if (glitch && h == 3) mode_in = (j >= 5 && j < 10);
        if (mode == 1'b0) begin
          b   = (j < 24) ? w[23-j] : 1'b1;
          esd = (h >= 1 && j < KEEP) ? b : 1'b0;
          ews = (j >= KEEP) ? ~wsl : wsl;
          tsd = (h == 0) ? "R8" : ((j < KEEP) ? "R1 R6" : "R2");
          tws = "R3 R4";
        end else begin
          b   = (j >= len - RJ_W) ? w[RJ_W-1-(j-(len-RJ_W))] : 1'b1;
          esd = (h >= 1 && j >= len - RJ_W) ? b : 1'b0;
          ews = wsl;
          tsd = (h == 0) ? "R8" : "R7 data";
          tws = "R7 ws";
        end
        step(wsl, b, 1'b1, esd, ews, {tsd, extra}, {tws, extra});
      end
    end
    // drain pipeline without new expectations
    step(ws_in, 1'b0, 1'b0, 1'b0, 1'b0, "", "");
    step(ws_in, 1'b0, 1'b0, 1'b0, 1'b0, "", "");
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run(1'b0, 24, 8, 1'b0);
    run(1'b0, 25, 6, 1'b0);
    run(1'b0, 32, 8, 1'b0);
    run(1'b0, 40, 6, 1'b0);
    run(1'b0, 32, 6, 1'b1);
    run(1'b1, 18, 6, 1'b0);
    run(1'b1, 24, 6, 1'b0);
    run(1'b1, 32, 8, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(posedge bclk); #2;
      check(bclk_out, bclk, "R9 high phase");
      @(negedge bclk); #2;
      check(bclk_out, bclk, "R9 low phase");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule